// File: doc/BRIEF.md
# Two-Button LED Pattern Controller

This block lights four LEDs in one of two animated patterns chosen by two active-low push buttons. The style button chooses between a chase, where a single lit LED walks around the four positions, and a blink, where the whole vector flips polarity. The speed button cycles through four step periods, which are one, two, three and four half-seconds long.

Each button line passes through its own synchronizer and debounce filter. A filter emits one single-cycle press pulse for each accepted press, however long the button is held. A small state machine holds the current style and speed and updates on those pulses. A period counter then advances the selected pattern. The clock frequency and the debounce time are parameters, so a test build can shrink every interval to a few cycles.

Top module: `led_mode_ctrl`

## Requirements
- R1: While reset is asserted, and until the first accepted press after it, all four LEDs are lit (`led` = 4'b1111) and the controller is idle.
- R2: A press is accepted only after the button has been sampled low on DB_CYC consecutive clock edges, where DB_CYC = CLK_HZ*DEBOUNCE_US/1e6. Its effect appears at the second clock edge after the DB_CYC-th low sample. A low run shorter than DB_CYC samples is ignored. Holding the button gives exactly one press, and a new press needs at least one high sample first.
- R3: From idle, a style press starts the chase at speed step 1, and a speed press starts the blink at speed step 1. If both are accepted on the same edge, the style press wins.
- R4: In chase or blink, a speed press moves to the next longer step (1→2→3→4), and from step 4 it wraps to step 1. The style does not change.
- R5: In chase or blink, a style press switches to the other style and always sets speed step 1.
- R6: In chase or blink, when both presses are accepted on the same edge, only the speed press takes effect.
- R7: The chase starts at 4'b0001 and rotates right once per period (bit 0 moves to bit 3), giving 0001, 1000, 0100, 0010, 0001 and so on.
- R8: The blink starts at 4'b0110 and inverts all four bits once per period.
- R9: Speed step k lasts k*UNIT_CYC cycles, with UNIT_CYC = CLK_HZ/2. Any accepted press reloads the start pattern of the resulting style and restarts the period, so the first step after a change lasts one full new period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| btn_style_n | input | 1 | Raw style button, low when pressed |
| btn_speed_n | input | 1 | Raw speed button, low when pressed |
| led | output | 4 | LED drive, 1 = lit |

## Verification
The bench targets low runs of exactly DB_CYC-1 samples. A filter that counts one too few would accept these and change mode. Long holds are also driven, where a filter that does not lock would step the speed again and again. The bench presses both buttons on the same edge, both in idle and in an active mode. A reversed priority shows up there as the wrong style or a speed reset to step 1. It steps the speed past step 4, where a missing wrap leaves a dead fifth state. Each step is timed cycle by cycle after a change, which exposes an off-by-one terminal count and a period counter that is not restarted on a change.

// File: rtl/ledctl_pkg.sv
package ledctl_pkg;
  localparam int LED_W = 4;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CHASE = 2'd1,
    ST_BLINK = 2'd2
  } style_e;

  typedef logic [1:0] speed_t;

  localparam logic [LED_W-1:0] LED_ALL_ON  = 4'b1111;
  localparam logic [LED_W-1:0] CHASE_START = 4'b0001;
  localparam logic [LED_W-1:0] BLINK_START = 4'b0110;
endpackage

// File: rtl/btn_filter.sv
module btn_filter #(
  parameter int DB_CYC = 1_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic btn_n_i,
  output logic press_o
);
  localparam int CW = $clog2(DB_CYC + 1);
  localparam logic [CW-1:0] CNT_SAT  = CW'(DB_CYC);
  localparam logic [CW-1:0] CNT_FIRE = CW'(DB_CYC - 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          btn_low;

  assign btn_low = ~sync_q[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b11;
    else        sync_q <= {sync_q[0], btn_n_i};
  end

  always_comb begin
    cnt_d = cnt_q;
    if (!btn_low)                cnt_d = '0;
    else if (cnt_q != CNT_SAT)   cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign press_o = btn_low && (cnt_q == CNT_FIRE);

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    press_o |=> !press_o); // R2
endmodule

// File: rtl/mode_fsm.sv
module mode_fsm
  import ledctl_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   style_p_i,
  input  logic   speed_p_i,
  output style_e style_q_o,
  output style_e style_d_o,
  output speed_t speed_q_o,
  output logic   load_o
);
  style_e style_q, style_d;
  speed_t speed_q, speed_d;

  always_comb begin
    style_d = style_q;
    speed_d = speed_q;
    if (style_q == ST_IDLE) begin
      if (style_p_i) begin
        style_d = ST_CHASE;
        speed_d = '0;
      end else if (speed_p_i) begin
        style_d = ST_BLINK;
        speed_d = '0;
      end
    end else begin
      if (speed_p_i) begin
        speed_d = speed_q + 2'd1;
      end else if (style_p_i) begin
        style_d = (style_q == ST_CHASE) ? ST_BLINK : ST_CHASE;
        speed_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      style_q <= ST_IDLE;
      speed_q <= '0;
    end else begin
      style_q <= style_d;
      speed_q <= speed_d;
    end
  end

  assign style_q_o = style_q;
  assign style_d_o = style_d;
  assign speed_q_o = speed_q;
  assign load_o    = style_p_i | speed_p_i;

  AST_IDLE_STYLE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (style_q == ST_IDLE && style_p_i) |=> (style_q == ST_CHASE && speed_q == 2'd0)); // R3
  AST_SPEED_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (style_q != ST_IDLE && speed_p_i) |=>
      (speed_q == $past(speed_q) + 2'd1 && style_q == $past(style_q))); // R4
  AST_STYLE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (style_q != ST_IDLE && style_p_i && !speed_p_i) |=>
      (speed_q == 2'd0 && style_q != ST_IDLE && style_q != $past(style_q))); // R5
endmodule

// File: rtl/pattern_gen.sv
module pattern_gen
  import ledctl_pkg::*;
#(
  parameter int UNIT_CYC = 25_000_000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  style_e           style_q_i,
  input  style_e           style_d_i,
  input  speed_t           speed_q_i,
  input  logic             load_i,
  output logic [LED_W-1:0] led_o
);
  localparam int PW = $clog2(4 * UNIT_CYC + 1);

  logic [PW-1:0]    cnt_q, cnt_d, limit;
  logic [LED_W-1:0] pat_q, pat_d;
  logic             active, step_en;

  always_comb begin
    unique case (speed_q_i)
      2'd0:    limit = PW'(UNIT_CYC - 1);
      2'd1:    limit = PW'(2 * UNIT_CYC - 1);
      2'd2:    limit = PW'(3 * UNIT_CYC - 1);
      default: limit = PW'(4 * UNIT_CYC - 1);
    endcase
  end

  assign active  = (style_q_i != ST_IDLE);
  assign step_en = active && !load_i && (cnt_q == limit);

  always_comb begin
    cnt_d = cnt_q;
    pat_d = pat_q;
    if (load_i) begin
      cnt_d = '0;
      pat_d = (style_d_i == ST_BLINK) ? BLINK_START : CHASE_START;
    end else if (step_en) begin
      cnt_d = '0;
      pat_d = (style_q_i == ST_CHASE) ? {pat_q[0], pat_q[LED_W-1:1]} : ~pat_q;
    end else if (active) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pat_q <= CHASE_START;
    end else begin
      cnt_q <= cnt_d;
      pat_q <= pat_d;
    end
  end

  assign led_o = active ? pat_q : LED_ALL_ON;

  AST_CHASE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (style_q_i == ST_CHASE) |-> ($countones(pat_q) == 1)); // R7
  AST_BLINK_INVERT: assert property (@(posedge clk) disable iff (!rst_n)
    (style_q_i == ST_BLINK && step_en) |=> (pat_q == ~$past(pat_q))); // R8
  AST_CNT_IN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= limit); // R9
  AST_LOAD_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (cnt_q == '0)); // R9
endmodule

// File: rtl/led_mode_ctrl.sv
module led_mode_ctrl
  import ledctl_pkg::*;
#(
  parameter int CLK_HZ      = 50_000_000,
  parameter int DEBOUNCE_US = 20_000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             btn_style_n,
  input  logic             btn_speed_n,
  output logic [LED_W-1:0] led
);
  localparam longint DB_L     = (longint'(CLK_HZ) * longint'(DEBOUNCE_US)) / 64'sd1_000_000;
  localparam int     DB_CYC   = (DB_L < 1) ? 1 : int'(DB_L);
  localparam int     UNIT_CYC = (CLK_HZ / 2 < 1) ? 1 : CLK_HZ / 2;

  logic [1:0] rst_sync_q;
  logic       rst_ni;
  logic [1:0] raw_n, press;
  style_e     style_q, style_d;
  speed_t     speed_q;
  logic       load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  assign raw_n = {btn_speed_n, btn_style_n};

  for (genvar gi = 0; gi < 2; gi++) begin : g_btn
    btn_filter #(.DB_CYC(DB_CYC)) u_filter (
      .clk     (clk),
      .rst_n   (rst_ni),
      .btn_n_i (raw_n[gi]),
      .press_o (press[gi])
    );
  end

  mode_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_ni),
    .style_p_i (press[0]),
    .speed_p_i (press[1]),
    .style_q_o (style_q),
    .style_d_o (style_d),
    .speed_q_o (speed_q),
    .load_o    (load)
  );

  pattern_gen #(.UNIT_CYC(UNIT_CYC)) u_pat (
    .clk       (clk),
    .rst_n     (rst_ni),
    .style_q_i (style_q),
    .style_d_i (style_d),
    .speed_q_i (speed_q),
    .load_i    (load),
    .led_o     (led)
  );

  AST_RESET_ALL_ON: assert property (@(posedge clk) disable iff (!rst_ni)
    (style_q == ST_IDLE) |-> (led == LED_ALL_ON)); // R1
endmodule

// File: tb/test_led_mode_ctrl.sv
module test_led_mode_ctrl;
  localparam int CLK_HZ = 20;
  localparam int DEB_US = 250_000;
  localparam int DB     = 5;
  localparam int UNIT   = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       b_sty, b_spd;
  logic [3:0] led;

  int    n_vec = 0;
  int    n_bad = 0;
  bit    done  = 0;
  string tag   = "R1";

  // reference model state
  int       m_style;   // 0 idle, 1 chase, 2 blink
  int       m_spd;
  int       m_cnt;
  logic [3:0] m_pat;
  int       lo_s, lo_p;
  bit       s1, s2, p1, p2;

  always #5 clk = ~clk;

  led_mode_ctrl #(.CLK_HZ(CLK_HZ), .DEBOUNCE_US(DEB_US)) i_led_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .btn_style_n(b_sty), .btn_speed_n(b_spd), .led(led)
  );

  function automatic logic [3:0] exp_led();
    return (m_style == 0) ? 4'b1111 : m_pat;
  endfunction

  task automatic model_reset();
    m_style = 0; m_spd = 0; m_cnt = 0; m_pat = 4'b0001;
    lo_s = 0; lo_p = 0; s1 = 0; s2 = 0; p1 = 0; p2 = 0;
  endtask

  task automatic model_edge(input bit in_s, input bit in_p);
    bit hs, hp, fs, fp;
    lo_s = in_s ? 0 : lo_s + 1;
    lo_p = in_p ? 0 : lo_p + 1;
    hs = (lo_s == DB);
    hp = (lo_p == DB);
    fs = s2; s2 = s1; s1 = hs;
    fp = p2; p2 = p1; p1 = hp;
    if (fs || fp) begin
      if (m_style == 0) begin
        m_style = fs ? 1 : 2;
        m_spd = 0;
        tag = "R3";
      end else if (fp) begin
        m_spd = (m_spd + 1) % 4;
        tag = fs ? "R6" : "R4";
      end else begin
        m_style = (m_style == 1) ? 2 : 1;
        m_spd = 0;
        tag = "R5";
      end
      m_pat = (m_style == 2) ? 4'b0110 : 4'b0001;
      m_cnt = 0;
    end else if (m_style != 0) begin
      if (m_cnt == (m_spd + 1) * UNIT - 1) begin
        m_cnt = 0;
        m_pat = (m_style == 1) ? {m_pat[0], m_pat[3:1]} : ~m_pat;
        tag = (m_style == 1) ? "R7" : "R8";
      end else begin
        m_cnt = m_cnt + 1;
      end
    end
  endtask

  task automatic check(input string t);
    n_vec++;
    if (led !== exp_led()) begin
      n_bad++;
      $display("FAIL %s: led=%b expected=%b at %0t", t, led, exp_led(), $time);
    end
  endtask

  // one cycle: drive at negedge, model the coming edge, compare at next negedge
  task automatic tick(input bit in_s, input bit in_p);
    b_sty = in_s; b_spd = in_p;
    model_edge(in_s, in_p);
    @(negedge clk);
    check(tag);
  endtask

  task automatic idle_cycles(input int n);
    for (int i = 0; i < n; i++) tick(1'b1, 1'b1);
  endtask

  task automatic press(input bit sty, input bit spd, input int len);
    for (int i = 0; i < len; i++) tick(!sty, !spd);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; b_sty = 1'b1; b_spd = 1'b1;
    model_reset();
    repeat (3) @(negedge clk);
    n_vec++;
    if (led !== 4'b1111) begin
      n_bad++;
      $display("FAIL R1: led=%b expected=%b in reset", led, 4'b1111);
    end
    rst_n = 1'b1;
    tag = "R1";
    idle_cycles(4);
  endtask

  initial begin
    int rs, rp, hs, hp;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; b_sty = 1'b1; b_spd = 1'b1;
    do_reset();

    // R2: glitch one sample short of acceptance is ignored
    tag = "R2"; press(1, 0, DB - 1); idle_cycles(20);
    tag = "R2"; press(0, 1, DB - 1); idle_cycles(20);
    // R2/R3: long hold gives one press into chase; R7 sequence, R9 timing
    press(1, 0, 60); idle_cycles(50);
    // R4: walk speed through all four steps and wrap
    for (int k = 0; k < 5; k++) begin press(0, 1, DB + 2); idle_cycles(3 * UNIT * (k % 4 + 1)); end
    // R5: style flip from a slow step, blink pattern R8
    press(0, 1, DB + 2); idle_cycles(25);
    press(1, 0, DB + 2); idle_cycles(60);
    // R6: both together in an active mode
    press(1, 1, DB + 3); idle_cycles(50);
    // R3: both together from idle
    do_reset();
    press(1, 1, DB + 3); idle_cycles(30);
    do_reset();
    press(0, 1, DB + 2); idle_cycles(30);

    // random phase
    rs = 0; rp = 0; hs = 1; hp = 1;
    for (int c = 0; c < 15000; c++) begin
      if (rs == 0) begin hs = !hs; rs = hs ? 1 + int'($urandom % 120) : 1 + int'($urandom % (DB + 8)); end
      if (rp == 0) begin hp = !hp; rp = hp ? 1 + int'($urandom % 120) : 1 + int'($urandom % (DB + 8)); end
      rs--; rp--;
      tick(hs, hp);
    end
    idle_cycles(100);

    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    #(10 * 200_000);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule